// File: doc/BRIEF.md
# Flag-Accurate Integer Adder-Subtractor

This block is an integer datapath of parameterised width (64 bits by default). It performs addition, addition with carry-in, subtraction, subtraction with borrow-in, negation, bitwise inversion and comparison. Alongside the result it keeps a six-bit status register with these flags: carry, parity, auxiliary carry, zero, sign and overflow. Every operation either rewrites that register or leaves it alone, according to its own rule.

All subtracting operations run as one pass through a single adder. The subtrahend is inverted and a carry-in of 1 is applied, so the carry-out, the nibble carry and the overflow describe the whole operation and not the pieces of it.

A mode input selects how a borrow is stored in the carry flag. In one mode the flag holds the borrow itself. In the other it holds the inverse of the borrow. Subtraction with borrow-in reads the carry flag using the same polarity, which lets multi-word arithmetic chain correctly in either mode.

A caller presents an opcode, two operands and a valid strobe. One clock edge later it reads the result and the flags, which are qualified by a one-cycle ready pulse.

Top module: `flag_alu`

## Requirements
- R1: Opcode 0 (add) yields a+b. Opcode 1 (add with carry) yields a+b+carry flag. The carry flag becomes the carry out of the most significant bit.
- R2: Opcode 2 (subtract) yields a-b in one adder pass. With `inv_borrow`=0 the carry flag becomes 1 exactly when a is unsigned-below b. For example, 0-1 gives all-ones with carry 1, 1-3 sets carry, and all-ones minus 0 clears carry.
- R3: With `inv_borrow`=1, subtract, subtract with borrow, compare and negate store the inverse of the borrow in the carry flag. Opcode 3 (subtract with borrow) computes a-b-borrow_in. Here borrow_in is the carry flag when `inv_borrow`=0 and its inverse when `inv_borrow`=1.
- R4: Overflow is the exact signed overflow of the true operation. For subtraction this includes subtracting the most-negative value. 0 minus the most-negative value sets overflow. -1 minus the most-negative value clears it.
- R5: The auxiliary flag is the carry out of bit 3 for add types. For subtract types it is the borrow out of bit 3, whatever the `inv_borrow` setting.
- R6: Zero is set when the result is all zeros. Sign is the result's most significant bit. Parity is set when bits 7..0 of the result hold an even number of ones.
- R7: Opcode 4 (negate) produces 0-a and sets every flag as a subtraction of a from zero would.
- R8: Opcode 5 (invert) produces ~a and leaves all six flags unchanged.
- R9: Opcode 6 (compare) sets the flags exactly as subtract does and leaves the result output unchanged.
- R10: Opcode 7 is reserved. It changes neither the result nor the flags, but still produces a ready pulse.
- R11: Result and flags update at the clock edge that samples `op_valid`=1. `res_ready` is high for exactly the following cycle. Without `op_valid`, result and flags hold.
- R12: A synchronous reset clears the result, all flags and `res_ready` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inv_borrow | input | 1 | Carry polarity after subtract types: 0 borrow, 1 inverted borrow |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | Operation selector (see R1-R10 encodings) |
| opnd_a | input | DATA_W | First operand |
| opnd_b | input | DATA_W | Second operand |
| res_out | output | DATA_W | Registered result |
| flag_c | output | 1 | Carry / borrow flag |
| flag_p | output | 1 | Parity flag |
| flag_a | output | 1 | Auxiliary (nibble) carry flag |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_o | output | 1 | Signed overflow flag |
| res_ready | output | 1 | One-cycle pulse marking new result and flags |

## Verification
The assertions assume that `op_code`, the operands and `inv_borrow` are stable and known whenever `op_valid` is high. They also assume reset is held for at least one edge before the first operation. The stimulus changes every input only at the falling edge, holds `op_valid` low in gaps, and never strobes during reset. Directed cases target the borrow corners, the most-negative operand and multi-word chains in both carry polarities. A mixed run then draws opcodes and mode from the full legal encoding, with operands biased toward zero, all-ones and the sign boundary.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBB = 3'd3,
        OP_NEG = 3'd4,
        OP_NOT = 3'd5,
        OP_CMP = 3'd6,
        OP_RSV = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic aux;
        logic par;
        logic cry;
    } alu_flags_t;

    function automatic logic op_is_arith(alu_op_e op);
        return (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) ||
               (op == OP_SBB) || (op == OP_NEG);
    endfunction

endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel
    import flag_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cf_in,
    input  logic              inv_borrow,
    output logic [DATA_W-1:0] x,
    output logic [DATA_W-1:0] y,
    output logic              cin,
    output logic              sub_path
);

    // Subtract types feed ~b and express the borrow-in as a carry-in.
    always_comb begin
        x        = a;
        y        = b;
        cin      = 1'b0;
        sub_path = 1'b0;
        case (op)
            OP_ADC: cin = cf_in;
            OP_SUB, OP_CMP: begin
                y        = ~b;
                cin      = 1'b1;
                sub_path = 1'b1;
            end
            OP_SBB: begin
                y        = ~b;
                cin      = inv_borrow ? cf_in : ~cf_in;
                sub_path = 1'b1;
            end
            OP_NEG: begin
                x        = '0;
                y        = ~a;
                cin      = 1'b1;
                sub_path = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              cout,
    output logic              c4,
    output logic              ovf
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] full;

    assign full = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
    assign sum  = full[MSB:0];
    assign cout = full[DATA_W];
    // Carry into bit 4 recovered from the sum bit and its inputs.
    assign c4   = x[4] ^ y[4] ^ full[4];
    assign ovf  = (x[MSB] == y[MSB]) && (full[MSB] != x[MSB]);

endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
    import flag_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] sum,
    input  logic              cout,
    input  logic              c4,
    input  logic              ovf,
    input  logic              sub_path,
    input  logic              inv_borrow,
    output alu_flags_t        flags
);

    localparam int PAR_W = (DATA_W < 8) ? DATA_W : 8;

    logic par_bit;

    generate
        if (PAR_W == 8) begin : g_par_byte
            assign par_bit = ~^sum[7:0];
        end else begin : g_par_narrow
            assign par_bit = ~^sum[PAR_W-1:0];
        end
    endgenerate

    always_comb begin
        flags.ovf = ovf;
        flags.sgn = sum[DATA_W-1];
        flags.zro = (sum == '0);
        flags.par = par_bit;
        if (sub_path) begin
            flags.aux = ~c4;
            flags.cry = inv_borrow ? cout : ~cout;
        end else begin
            flags.aux = c4;
            flags.cry = cout;
        end
    end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inv_borrow,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] res_out,
    output logic              flag_c,
    output logic              flag_p,
    output logic              flag_a,
    output logic              flag_z,
    output logic              flag_s,
    output logic              flag_o,
    output logic              res_ready
);

    typedef struct packed {
        logic [DATA_W-1:0] res;
        alu_flags_t        flg;
        logic              rdy;
    } alu_state_t;

    alu_state_t        st_d, st_q;
    alu_op_e           op;
    logic [DATA_W-1:0] add_x, add_y, add_sum;
    logic              add_cin, add_cout, add_c4, add_ovf, sub_path;
    alu_flags_t        calc_flags;

    assign op = alu_op_e'(op_code);

    alu_operand_sel #(.DATA_W(DATA_W)) u_sel (
        .op(op), .a(opnd_a), .b(opnd_b), .cf_in(st_q.flg.cry),
        .inv_borrow(inv_borrow), .x(add_x), .y(add_y), .cin(add_cin),
        .sub_path(sub_path)
    );

    alu_adder #(.DATA_W(DATA_W)) u_add (
        .x(add_x), .y(add_y), .cin(add_cin), .sum(add_sum),
        .cout(add_cout), .c4(add_c4), .ovf(add_ovf)
    );

    alu_flag_gen #(.DATA_W(DATA_W)) u_flg (
        .sum(add_sum), .cout(add_cout), .c4(add_c4), .ovf(add_ovf),
        .sub_path(sub_path), .inv_borrow(inv_borrow), .flags(calc_flags)
    );

    always_comb begin
        st_d     = st_q;
        st_d.rdy = op_valid;
        if (op_valid) begin
            case (op)
                OP_NOT:  st_d.res = ~opnd_a;
                OP_CMP:  st_d.flg = calc_flags;
                OP_RSV:  ;
                default: begin
                    st_d.res = add_sum;
                    st_d.flg = calc_flags;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign res_out   = st_q.res;
    assign flag_c    = st_q.flg.cry;
    assign flag_p    = st_q.flg.par;
    assign flag_a    = st_q.flg.aux;
    assign flag_z    = st_q.flg.zro;
    assign flag_s    = st_q.flg.sgn;
    assign flag_o    = st_q.flg.ovf;
    assign res_ready = st_q.rdy;

    assert_ready_follows_valid_R11: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_ready);
    assert_idle_holds_R11: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> !res_ready && $stable(res_out) && $stable({flag_o, flag_s, flag_z, flag_a, flag_p, flag_c}));
    assert_invert_keeps_flags_R8: assert property (@(posedge clk) disable iff (rst)
        op_valid && op == OP_NOT |=> $stable({flag_o, flag_s, flag_z, flag_a, flag_p, flag_c}));
    assert_compare_keeps_result_R9: assert property (@(posedge clk) disable iff (rst)
        op_valid && op == OP_CMP |=> $stable(res_out));
    assert_reserved_inert_R10: assert property (@(posedge clk) disable iff (rst)
        op_valid && op == OP_RSV |=> $stable(res_out) && $stable({flag_o, flag_s, flag_z, flag_a, flag_p, flag_c}));
    assert_zero_sign_track_R6: assert property (@(posedge clk) disable iff (rst)
        op_valid && op_is_arith(op) |=> (flag_z == (res_out == '0)) && (flag_s == res_out[DATA_W-1]));

endmodule

// File: tb/flag_alu_bench.sv
module flag_alu_bench;

    localparam int  W      = 64;
    localparam time PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         inv_borrow = 1'b0;
    logic         op_valid = 1'b0;
    logic [2:0]   op_code = '0;
    logic [W-1:0] opnd_a = '0, opnd_b = '0;
    logic [W-1:0] res_out;
    logic         flag_c, flag_p, flag_a, flag_z, flag_s, flag_o, res_ready;

    int n_checks = 0;
    int n_fails  = 0;

    logic [W-1:0] exp_res_q[$];
    logic [5:0]   exp_flg_q[$];
    string        exp_tag_q[$];

    // model state, flags packed {o,s,z,a,p,c}
    logic [W-1:0] m_res = '0;
    logic [5:0]   m_flg = '0;

    localparam logic [W-1:0] ONES = '1;
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};

    always #(PERIOD/2) clk = ~clk;

    flag_alu #(.DATA_W(W)) u_flag_alu (
        .clk(clk), .rst(rst), .inv_borrow(inv_borrow), .op_valid(op_valid),
        .op_code(op_code), .opnd_a(opnd_a), .opnd_b(opnd_b), .res_out(res_out),
        .flag_c(flag_c), .flag_p(flag_p), .flag_a(flag_a), .flag_z(flag_z),
        .flag_s(flag_s), .flag_o(flag_o), .res_ready(res_ready)
    );

    function automatic logic [5:0] port_flags();
        return {flag_o, flag_s, flag_z, flag_a, flag_p, flag_c};
    endfunction

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic void model(logic [2:0] op, logic [W-1:0] a, logic [W-1:0] b, logic mode);
        logic [W+1:0] ux, uy, ur, sx, sy, sr;
        logic [4:0]   nib;
        logic [W-1:0] xa, yb, r;
        logic         cin, c, o, af;
        logic         cf = m_flg[0];
        case (op)
            3'd0, 3'd1: begin
                cin = (op == 3'd1) ? cf : 1'b0;
                ux = {2'b00, a}; uy = {2'b00, b};
                ur = ux + uy + {{(W+1){1'b0}}, cin};
                sx = {{2{a[W-1]}}, a}; sy = {{2{b[W-1]}}, b};
                sr = sx + sy + {{(W+1){1'b0}}, cin};
                nib = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'b0, cin};
                r = ur[W-1:0]; c = ur[W]; o = sr[W] ^ sr[W-1]; af = nib[4];
                m_res = r;
                m_flg = {o, r[W-1], r == '0, af, ~^r[7:0], c};
            end
            3'd2, 3'd3, 3'd4, 3'd6: begin
                xa  = (op == 3'd4) ? '0 : a;
                yb  = (op == 3'd4) ? a : b;
                cin = (op == 3'd3) ? (mode ? ~cf : cf) : 1'b0;   // borrow-in
                ux = {2'b00, xa}; uy = {2'b00, yb};
                ur = ux - uy - {{(W+1){1'b0}}, cin};
                sx = {{2{xa[W-1]}}, xa}; sy = {{2{yb[W-1]}}, yb};
                sr = sx - sy - {{(W+1){1'b0}}, cin};
                nib = {1'b0, xa[3:0]} - {1'b0, yb[3:0]} - {4'b0, cin};
                r = ur[W-1:0]; o = sr[W] ^ sr[W-1]; af = nib[4];
                c = mode ? ~ur[W+1] : ur[W+1];
                if (op != 3'd6) m_res = r;
                m_flg = {o, r[W-1], r == '0, af, ~^r[7:0], c};
            end
            3'd5: m_res = ~a;
            default: ;
        endcase
    endfunction

    task automatic issue(logic [2:0] op, logic [W-1:0] a, logic [W-1:0] b, logic mode, string tag);
        @(negedge clk);
        op_valid = 1'b1; op_code = op; opnd_a = a; opnd_b = b; inv_borrow = mode;
        model(op, a, b, mode);
        exp_res_q.push_back(m_res);
        exp_flg_q.push_back(m_flg);
        exp_tag_q.push_back(tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            op_valid = 1'b0;
            op_code = $urandom;
            opnd_a = {$urandom, $urandom};
        end
    endtask

    // monitor: compare each ready pulse against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst && res_ready) begin
                if (exp_res_q.size() == 0) begin
                    check("R11 unexpected ready", 64'd1, 64'd0);
                end else begin
                    string tg = exp_tag_q.pop_front();
                    check({tg, " result"}, res_out, exp_res_q.pop_front());
                    check({tg, " flags{o,s,z,a,p,c}"}, {58'd0, port_flags()}, {58'd0, exp_flg_q.pop_front()});
                end
            end
        end
    end

    initial begin
        #(PERIOD * 100000);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R12 reset result", res_out, '0);
        check("R12 reset flags", {58'd0, port_flags()}, '0);
        check("R12 reset ready", {63'd0, res_ready}, '0);

        issue(3'd0, 64'd1, 64'd2, 1'b0, "R1 add small");
        issue(3'd0, ONES, 64'd1, 1'b0, "R1 add wrap carry R5");
        issue(3'd1, 64'd5, 64'd6, 1'b0, "R1 adc carry-in");
        issue(3'd0, MAXV, 64'd1, 1'b0, "R4 add overflow");
        issue(3'd0, 64'h0F, 64'h01, 1'b0, "R5 add nibble carry");
        issue(3'd2, 64'd0, 64'd1, 1'b0, "R2 0-1 borrow");
        issue(3'd2, 64'd1, 64'd3, 1'b0, "R2 1-3 borrow");
        issue(3'd2, ONES, 64'd0, 1'b0, "R2 ones-0 no borrow");
        issue(3'd2, 64'd0, MINV, 1'b0, "R4 0-min overflow");
        issue(3'd2, 64'd5, MINV, 1'b0, "R4 5-min overflow");
        issue(3'd2, ONES, MINV, 1'b0, "R4 -1-min no overflow");
        issue(3'd2, 64'd0, 64'd1, 1'b1, "R3 inverted 0-1");
        issue(3'd2, 64'd9, 64'd4, 1'b1, "R3 inverted 9-4");
        // multi-word 128-bit subtraction, both polarities
        issue(3'd2, 64'd0, 64'd1, 1'b0, "R3 sbb chain low");
        issue(3'd3, 64'd7, 64'd2, 1'b0, "R3 sbb chain high");
        issue(3'd2, 64'd0, 64'd1, 1'b1, "R3 sbb inv chain low");
        issue(3'd3, 64'd7, 64'd2, 1'b1, "R3 sbb inv chain high");
        issue(3'd4, 64'd0, 64'd0, 1'b0, "R7 neg zero");
        issue(3'd4, 64'd1, 64'd0, 1'b0, "R7 neg one");
        issue(3'd4, MINV, 64'd0, 1'b0, "R7 neg min overflow");
        issue(3'd4, 64'd3, 64'd0, 1'b1, "R7 neg inverted mode");
        issue(3'd5, 64'h00FF_0000_1234_5678, 64'd0, 1'b0, "R8 invert keeps flags");
        issue(3'd6, 64'd2, 64'd8, 1'b0, "R9 compare keeps result");
        issue(3'd7, ONES, ONES, 1'b0, "R10 reserved inert");
        issue(3'd0, 64'h3, 64'h0, 1'b0, "R6 parity even");
        issue(3'd0, 64'h7, 64'h0, 1'b0, "R6 parity odd");
        idle(4);
        #1;
        check("R11 hold result", res_out, m_res);
        check("R11 hold flags", {58'd0, port_flags()}, {58'd0, m_flg});

        for (int i = 0; i < 400; i++) begin
            logic [W-1:0] ra, rb;
            int sel = $urandom % 5;
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            if (sel == 0) ra = '0;
            if (sel == 1) rb = ONES;
            if (sel == 2) rb = MINV;
            issue(3'($urandom % 8), ra, rb, 1'($urandom), "R1 R2 R3 R4 R5 R6 mixed");
            if ((i % 7) == 0) idle(1);
        end
        idle(3);
        if (exp_res_q.size() != 0)
            check("R11 pending results", 64'(exp_res_q.size()), 64'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule